// File: doc/BRIEF.md
# Quad-Channel Overcurrent Retry Controller

This block holds the digital control for four switched outputs. Each channel takes an on/off command and an overcurrent flag, and it drives one output enable. While a channel reports no trouble, its output follows its command. When overcurrent appears, the channel does not latch off. It keeps the output on in a current-limited phase for a programmed number of cycles. If the overcurrent is still present at the end of that phase, it forces the output off for a second programmed number of cycles, then tries again. The retry keeps going for as long as the fault lasts.

Undervoltage, overtemperature and an active-low asynchronous reset are shared by all channels and switch every output off. A single active-low diagnostic output is low when either global fault is present or when any channel is in its forced-off phase. The limited-on phase is not reported on it. The two interval lengths are 16-bit cycle counts. When the off count is zero, the off interval is 64 times the on interval. When both counts are zero, the retry protection is turned off.

Each channel runs its own state machine with four states. IDLE has the output off. RUN has the output on with no fault. LIMIT has the output on while the limited-on count runs. BACKOFF has the output off while the forced-off count runs. The transitions are:
- *start*: IDLE→RUN.
- *trip*: RUN→LIMIT.
- *expire-hold*: LIMIT→BACKOFF.
- *expire-clear*: LIMIT→RUN.
- *retry*: BACKOFF→LIMIT.
- *recover*: BACKOFF→RUN.
- *drop*: any state→IDLE, taken when the command goes low or a global fault is present.

Top module: `quad_retry_ctrl`

## Requirements
- R1: Each channel i controls bit i of `drv_en` from `cmd[i]` and `ovc[i]` only. An overcurrent retry on one channel leaves every other channel's output unchanged.
- R2: A channel in RUN with `ovc` high and protection enabled enters LIMIT on the next edge. Its output then stays on for exactly `on_ticks` cycles, with 0 treated as 1.
- R3: If `ovc` is high in the last LIMIT cycle, the channel enters BACKOFF. Its output is off for exactly the off-interval length.
- R4: At the end of BACKOFF the channel goes straight to LIMIT if `ovc` is high, and to RUN otherwise. At the end of LIMIT with `ovc` low, the channel goes to RUN.
- R5: When `off_ticks` is 0 and `on_ticks` is not 0, the off interval is 64 × `on_ticks` cycles.
- R6: When `on_ticks` and `off_ticks` are both 0, `ovc` has no effect. The output stays on and `diag_n` stays high.
- R7: `diag_n` is low during every cycle in which any channel is in BACKOFF. It stays high during LIMIT if no other fault is present.
- R8: `diag_n` is low in any cycle in which `uv` or `ot` is high.
- R9: `rst_n` low forces all of `drv_en` to 0 at once, without waiting for a clock edge. `uv` or `ot` high forces all of `drv_en` to 0 in the same cycle and sends every channel to IDLE on the next edge.
- R10: The length of each interval is taken from the inputs at the cycle the interval starts. Changing `on_ticks` or `off_ticks` later does not alter an interval that is already running.
- R11: `cmd[i]` low sends channel i to IDLE on the next edge from any state. Its output goes off and its count is cleared.
- R12: After `uv`, `ot` or `rst_n` clears, each channel spends one cycle in IDLE and then follows its command, with its output on from the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; all outputs off while low |
| cmd | input | 4 | Per-channel on command, bit i for channel i |
| ovc | input | 4 | Per-channel overcurrent flag |
| uv | input | 1 | Undervoltage present |
| ot | input | 1 | Overtemperature present |
| on_ticks | input | 16 | Limited-on interval in cycles |
| off_ticks | input | 16 | Forced-off interval in cycles; 0 selects 64 × on_ticks |
| drv_en | output | 4 | Per-channel output enable |
| diag_n | output | 1 | Active-low combined fault indicator |

## Verification
The case that needs care is undervoltage arriving in the exact cycle a channel's forced-off count expires. Two things then compete in one cycle: the retry decision, which is based on overcurrent, and the global drop. The bench measures the BACKOFF length at the ports and raises `uv` at the negative edge before the final BACKOFF edge. It expects the output to stay off and `diag_n` to stay low on that edge, and it expects the channel to be in IDLE afterwards rather than LIMIT. This is judged by seeing exactly one cycle of off output, with `diag_n` high, after `uv` and `ovc` clear, and then the output coming on.

// File: rtl/qrc_pkg.sv
package qrc_pkg;
    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_RUN     = 2'd1,
        CH_LIMIT   = 2'd2,
        CH_BACKOFF = 2'd3
    } ch_state_t;
endpackage

// File: rtl/qrc_interval.sv
// Derives effective interval lengths from the programmed counts.
module qrc_interval #(
    parameter int CW = 16,
    parameter int SH = 6,
    localparam int LW = CW + SH
) (
    input  logic [CW-1:0] on_ticks,
    input  logic [CW-1:0] off_ticks,
    output logic [LW-1:0] on_len,
    output logic [LW-1:0] off_len,
    output logic          prot_en
);
    always_comb begin
        on_len  = (on_ticks == '0) ? LW'(1) : LW'(on_ticks);
        off_len = (off_ticks == '0) ? {on_ticks, {SH{1'b0}}} : LW'(off_ticks);
        prot_en = (on_ticks != '0) || (off_ticks != '0);
    end
endmodule

// File: rtl/qrc_diag.sv
// Merges global and per-channel fault sources.
module qrc_diag #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] backoff,
    input  logic           uv,
    input  logic           ot,
    output logic           blk,
    output logic           diag_n
);
    always_comb begin
        blk    = uv | ot;
        diag_n = ~(blk | (|backoff));
    end
endmodule

// File: rtl/qrc_channel.sv
// One channel: retry state machine with its interval counter.
module qrc_channel
    import qrc_pkg::*;
#(
    parameter int LW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd,
    input  logic          ovc,
    input  logic          blk,
    input  logic          prot_en,
    input  logic [LW-1:0] on_len,
    input  logic [LW-1:0] off_len,
    output logic          drive_on,
    output logic          in_backoff
);
    ch_state_t     st, st_nx;
    logic [LW-1:0] cnt, cnt_nx;
    logic          last;

    assign last = (cnt <= LW'(1));

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        if (blk || !cmd) begin
            st_nx  = CH_IDLE;
            cnt_nx = '0;
        end else begin
            unique case (st)
                CH_IDLE: st_nx = CH_RUN;
                CH_RUN: begin
                    if (ovc && prot_en) begin
                        st_nx  = CH_LIMIT;
                        cnt_nx = on_len;
                    end
                end
                CH_LIMIT: begin
                    if (!last) begin
                        cnt_nx = cnt - LW'(1);
                    end else if (ovc) begin
                        st_nx  = CH_BACKOFF;
                        cnt_nx = off_len;
                    end else begin
                        st_nx  = CH_RUN;
                        cnt_nx = '0;
                    end
                end
                CH_BACKOFF: begin
                    if (!last) begin
                        cnt_nx = cnt - LW'(1);
                    end else if (ovc) begin
                        st_nx  = CH_LIMIT;
                        cnt_nx = on_len;
                    end else begin
                        st_nx  = CH_RUN;
                        cnt_nx = '0;
                    end
                end
                default: begin
                    st_nx  = CH_IDLE;
                    cnt_nx = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= CH_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        drive_on   = (st == CH_RUN) || (st == CH_LIMIT);
        in_backoff = (st == CH_BACKOFF);
    end

    assert_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_RUN && ovc && prot_en && cmd && !blk) |=> (st == CH_LIMIT));

    assert_limit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_LIMIT && !last && cmd && !blk) |=> (st == CH_LIMIT));

    assert_backoff_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_BACKOFF && !last && cmd && !blk) |=> (st == CH_BACKOFF));

    assert_expire_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_LIMIT && last && ovc && cmd && !blk) |=> (st == CH_BACKOFF));

    assert_no_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_RUN && !prot_en && cmd && !blk) |=> (st == CH_RUN));

    assert_global_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        blk |=> (st == CH_IDLE && cnt == '0));

    assert_cmd_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd |=> (st == CH_IDLE));
endmodule

// File: rtl/quad_retry_ctrl.sv
module quad_retry_ctrl #(
    parameter int NCH = 4,
    parameter int CW  = 16,
    parameter int SH  = 6,
    localparam int LW = CW + SH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cmd,
    input  logic [NCH-1:0] ovc,
    input  logic           uv,
    input  logic           ot,
    input  logic [CW-1:0]  on_ticks,
    input  logic [CW-1:0]  off_ticks,
    output logic [NCH-1:0] drv_en,
    output logic           diag_n
);
    logic [LW-1:0]  on_len, off_len;
    logic           prot_en, blk;
    logic [NCH-1:0] drive_on, backoff;

    qrc_interval #(.CW(CW), .SH(SH)) u_interval (
        .on_ticks (on_ticks),
        .off_ticks(off_ticks),
        .on_len   (on_len),
        .off_len  (off_len),
        .prot_en  (prot_en)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        qrc_channel #(.LW(LW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd       (cmd[i]),
            .ovc       (ovc[i]),
            .blk       (blk),
            .prot_en   (prot_en),
            .on_len    (on_len),
            .off_len   (off_len),
            .drive_on  (drive_on[i]),
            .in_backoff(backoff[i])
        );
    end

    qrc_diag #(.NCH(NCH)) u_diag (
        .backoff(backoff),
        .uv     (uv),
        .ot     (ot),
        .blk    (blk),
        .diag_n (diag_n)
    );

    assign drv_en = rst_n ? (drive_on & {NCH{~blk}}) : '0;

    assert_backoff_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (backoff != '0) |-> !diag_n);

    assert_fault_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (uv || ot) |-> (drv_en == '0 && !diag_n));
endmodule

// File: tb/quad_retry_ctrl_test.sv
`timescale 1ns/1ps
module quad_retry_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  cmd, ovc;
    logic        uv, ot;
    logic [15:0] on_t, off_t;
    logic [3:0]  drv_en;
    logic        diag_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    quad_retry_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .ovc(ovc), .uv(uv), .ot(ot),
        .on_ticks(on_t), .off_ticks(off_t), .drv_en(drv_en), .diag_n(diag_n)
    );

    // {cmd, ovc, uv, ot, expected drv_en, expected diag_n}, protection off
    localparam logic [14:0] VEC [8] = '{
        {4'b1111, 4'b0000, 1'b0, 1'b0, 4'b1111, 1'b1},
        {4'b1111, 4'b1111, 1'b0, 1'b0, 4'b1111, 1'b1},
        {4'b0101, 4'b1010, 1'b0, 1'b0, 4'b0101, 1'b1},
        {4'b1111, 4'b0000, 1'b1, 1'b0, 4'b0000, 1'b0},
        {4'b1111, 4'b0000, 1'b0, 1'b1, 4'b0000, 1'b0},
        {4'b1111, 4'b1111, 1'b1, 1'b1, 4'b0000, 1'b0},
        {4'b0011, 4'b0011, 1'b0, 1'b0, 4'b0011, 1'b1},
        {4'b0000, 4'b0000, 1'b0, 1'b0, 4'b0000, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic adv(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // count consecutive negedge samples with drv_en[0] == lvl
    task automatic run_len(input logic lvl, input int limit, output int n);
        n = 0;
        while (drv_en[0] == lvl && n < limit) begin
            n++;
            adv();
        end
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        rst_n = 1'b0; cmd = '0; ovc = '0; uv = 1'b0; ot = 1'b0;
        on_t = '0; off_t = '0;
        @(negedge clk);
        #1;
        chk("reset drv R9", drv_en, 0);
        chk("reset diag R8", diag_n, 1);
        adv(2);
        rst_n = 1'b1;
        adv();

        // vector table, protection disabled (R6, R8, R9, R12, R1)
        for (int i = 0; i < 8; i++) begin
            cmd = VEC[i][14:11]; ovc = VEC[i][10:7];
            uv = VEC[i][6]; ot = VEC[i][5];
            adv(2);
            chk($sformatf("vec%0d drv R6 R9 R12", i), drv_en, VEC[i][4:1]);
            chk($sformatf("vec%0d diag R6 R8", i), diag_n, VEC[i][0]);
        end

        // retry timing on channel 0, channel 1 plain (R1, R2, R3, R4, R7)
        on_t = 16'd3; off_t = 16'd5; ovc = '0;
        cmd = 4'b0011;
        adv();
        chk("run R1", drv_en, 4'b0011);
        ovc[0] = 1'b1;
        adv();
        run_len(1'b1, 50, n);
        chk("limit len R2", n, 3);
        chk("backoff diag R7", diag_n, 0);
        chk("other ch R1", drv_en[1], 1);
        run_len(1'b0, 50, n);
        chk("backoff len R3", n, 5);
        chk("limit diag R7", diag_n, 1);
        run_len(1'b1, 50, n);
        chk("retry limit len R4", n, 3);
        ovc[0] = 1'b0;
        run_len(1'b0, 50, n);
        chk("recover backoff len R4", n, 5);
        adv(10);
        chk("recover run R4", drv_en, 4'b0011);
        chk("recover diag R4", diag_n, 1);
        ovc[0] = 1'b1;
        adv();
        ovc[0] = 1'b0;
        adv(5);
        chk("limit clear to run R4", drv_en[0], 1);
        chk("limit clear diag R4", diag_n, 1);

        // default off interval and sampling (R5, R10)
        on_t = 16'd2; off_t = '0;
        ovc[0] = 1'b1;
        adv();
        run_len(1'b1, 50, n);
        chk("limit len R2", n, 2);
        on_t = 16'd1;
        run_len(1'b0, 400, n);
        chk("default off 64x R5 R10", n, 128);
        run_len(1'b1, 50, n);
        chk("new on sampled R10", n, 1);

        // command drop during backoff (R11)
        cmd[0] = 1'b0;
        adv();
        chk("drop drv R11", drv_en[0], 0);
        chk("drop diag R11", diag_n, 1);
        cmd[0] = 1'b1; ovc[0] = 1'b0;
        adv();
        chk("drop restart R11", drv_en[0], 1);

        // undervoltage on the final backoff cycle (R9, R12, R7)
        on_t = 16'd2; off_t = 16'd4;
        ovc[0] = 1'b1;
        adv();
        run_len(1'b1, 50, n);
        chk("limit len R2", n, 2);
        adv(3);
        uv = 1'b1;
        #1;
        chk("uv at expiry drv R9", drv_en, 0);
        chk("uv at expiry diag R8", diag_n, 0);
        adv();
        chk("uv held drv R9", drv_en, 0);
        uv = 1'b0; ovc[0] = 1'b0;
        #1;
        chk("idle after uv drv R12", drv_en, 0);
        chk("idle after uv diag R12", diag_n, 1);
        adv();
        chk("restart after uv R12", drv_en, 4'b0011);

        // asynchronous reset mid-cycle (R9, R12)
        adv(2);
        #5 rst_n = 1'b0;
        #1;
        chk("async reset drv R9", drv_en, 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("idle after reset R12", drv_en, 0);
        adv();
        chk("restart after reset R12", drv_en, 4'b0011);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule